// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block lets a host bring up a single SDR SDRAM device one command at a time. The host presents a packed command word together with a one-cycle write strobe. The word selects the operation, the internal bank, how many times an auto-refresh repeats, and the mode-register payload. The block places that command on the memory's control, bank and address pins for one clock. It then holds a busy flag until the timing gap that the command needs has elapsed, so the host can poll busy before it sends the next step.

A typical power-up runs as follows. The host enables the clock, waits at least 100 µs on its own, precharges all banks, issues eight auto-refresh commands as one repeated request, and then loads the mode register. A write that arrives while the block is busy is dropped and sets an error flag that stays set until reset. Data transfers and periodic refresh are handled elsewhere.

Top module: `sdcmd_engine`

## Requirements
- R1: While reset is asserted and after it is released: busy is 0, err is 0, sd_cke is 0, sd_cs_n is 1, and sd_ras_n, sd_cas_n and sd_we_n are 1.
- R2: Command word fields are as follows. Bits 2:0 hold the operation code: 1 = clock enable, 2 = precharge all, 3 = auto-refresh, 4 = load mode. Bits 4:3 hold the bank, which is driven on sd_ba with the command. Bits 8:5 hold the auto-refresh count minus one. Bits 20:9 hold the mode-register payload.
- R3: An accepted write puts its command on the pins during the clock after the accepting edge, for exactly one clock. Otherwise the device is deselected (sd_cs_n = 1, sd_ras_n, sd_cas_n and sd_we_n = 1). The {ras_n,cas_n,we_n} values are: clock enable 111 with cs_n low, precharge all 010, auto-refresh 001, load mode 000.
- R4: sd_cke rises together with the clock-enable command and then stays high under every later command until reset.
- R5: Precharge all drives sd_addr bit 10 high and every other address bit low. Busy lasts T_RP = 2 clocks. Clock enable drives address 0 and keeps busy for T_CKE = 1 clock.
- R6: Auto-refresh with count field c issues c+1 refresh commands, each T_RC = 7 clocks after the previous one. Busy lasts (c+1)·7 clocks and the address is 0. The boundary c = 15 gives 16 refreshes.
- R7: Load mode drives the payload onto sd_addr, and busy lasts T_MRD = 2 clocks.
- R8: A write while busy issues nothing, leaves the command in progress unchanged (same count, spacing and busy length), and sets err, which stays set until reset.
- R9: Operation codes 0, 5, 6 and 7 issue nothing. Busy stays 0 and err is not set.
- R10: A write on the last busy clock is rejected and flags err. A write on the first clock after busy clears is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle write strobe for the command word |
| cmd_word | input | 21 | Packed command word |
| busy | output | 1 | Command or its trailing wait in progress |
| err | output | 1 | Sticky flag: a write arrived while busy |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM address / mode payload |

## Verification
Two events can land on the same clock edge: the timer releasing busy, and a new host write arriving. The bench holds the write strobe on the final busy clock of a precharge and expects rejection, a raised error flag and no pin activity. It then repeats the write one clock later and expects the load-mode pattern on the pins at once. A second collision is a write arriving in the middle of a repeated refresh, on the same cycle the timer is counting toward a reissue. That case is judged by the count and spacing of the refreshes and by the unchanged busy length.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_CKE  = 3'd1,
    K_PALL = 3'd2,
    K_REF  = 3'd3,
    K_LMR  = 3'd4
  } cmd_kind_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_pat_t;

  function automatic logic kind_known(input logic [2:0] k);
    return (k == K_CKE) || (k == K_PALL) || (k == K_REF) || (k == K_LMR);
  endfunction

  function automatic pin_pat_t pat_of(input logic [2:0] k);
    case (k)
      K_PALL:  return 3'b010;
      K_REF:   return 3'b001;
      K_LMR:   return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  // clocks of busy per issued command, counting the command clock itself
  function automatic int unsigned hold_of(input logic [2:0] k, input int unsigned t_cke,
                                          input int unsigned t_rp, input int unsigned t_rc,
                                          input int unsigned t_mrd);
    case (k)
      K_CKE:   return t_cke;
      K_PALL:  return t_rp;
      K_REF:   return t_rc;
      K_LMR:   return t_mrd;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int REP_W  = 4,
  parameter int HOLD_W = 3,
  parameter int unsigned T_CKE = 1,
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RC  = 7,
  parameter int unsigned T_MRD = 2,
  localparam int BANK_LSB = 3,
  localparam int REP_LSB  = BANK_LSB + BANK_W,
  localparam int MODE_LSB = REP_LSB + REP_W,
  localparam int WORD_W   = MODE_LSB + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              kind_ok,
  output logic              is_cke,
  output pin_pat_t          pat,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic [REP_W-1:0]  rep,
  output logic [HOLD_W-1:0] hold
);
  logic [2:0] kind;

  always_comb begin
    kind    = word[2:0];
    kind_ok = kind_known(kind);
    is_cke  = (kind == K_CKE);
    pat     = pat_of(kind);
    bank    = word[REP_LSB-1:BANK_LSB];
    rep     = (kind == K_REF) ? word[MODE_LSB-1:REP_LSB] : '0;
    hold    = HOLD_W'(hold_of(kind, T_CKE, T_RP, T_RC, T_MRD));
    addr    = '0;
    if (kind == K_LMR)  addr = word[WORD_W-1:MODE_LSB];
    if (kind == K_PALL) addr[10] = 1'b1;
  end
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int HOLD_W = 3,
  parameter int REP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic [REP_W-1:0]  rep_in,
  output logic              busy,
  output logic              reissue
);
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] hold_q;
  logic [REP_W-1:0]  rem;
  logic              span_end;

  assign span_end = busy && (cnt == '0);
  assign reissue  = span_end && (rem != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      hold_q <= '0;
      rem    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= hold_len - HOLD_W'(1);
      hold_q <= hold_len;
      rem    <= rep_in;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - HOLD_W'(1);
      end else if (rem != '0) begin
        rem <= rem - REP_W'(1);
        cnt <= hold_q - HOLD_W'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end

  AST_WAIT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy); // R6
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R10
  AST_REISSUE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reissue |=> busy); // R6
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int REP_W  = 4,
  parameter int unsigned T_CKE = 1,
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RC  = 7,
  parameter int unsigned T_MRD = 2,
  localparam int WORD_W = 3 + BANK_W + REP_W + ADDR_W,
  localparam int HOLD_W = $clog2(max4(T_CKE, T_RP, T_RC, T_MRD) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              busy,
  output logic              err,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  logic              kind_ok;
  logic              is_cke;
  pin_pat_t          pat_d;
  logic [BANK_W-1:0] bank_d;
  logic [ADDR_W-1:0] addr_d;
  logic [REP_W-1:0]  rep_d;
  logic [HOLD_W-1:0] hold_d;
  logic              accept;
  logic              reject;
  logic              reissue;

  sdcmd_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REP_W(REP_W), .HOLD_W(HOLD_W),
    .T_CKE(T_CKE), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
  ) u_dec (
    .word(cmd_word), .kind_ok(kind_ok), .is_cke(is_cke), .pat(pat_d),
    .bank(bank_d), .addr(addr_d), .rep(rep_d), .hold(hold_d)
  );

  assign accept = cmd_wr && !busy && kind_ok;
  assign reject = cmd_wr && busy;

  sdcmd_timer #(.HOLD_W(HOLD_W), .REP_W(REP_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .hold_len(hold_d),
    .rep_in(rep_d), .busy(busy), .reissue(reissue)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_cs_n  <= 1'b1;
      sd_ras_n <= 1'b1;
      sd_cas_n <= 1'b1;
      sd_we_n  <= 1'b1;
      sd_ba    <= '0;
      sd_addr  <= '0;
      sd_cke   <= 1'b0;
      err      <= 1'b0;
    end else begin
      sd_cs_n                       <= 1'b1;
      {sd_ras_n, sd_cas_n, sd_we_n} <= 3'b111;
      if (accept) begin
        sd_cs_n                       <= 1'b0;
        {sd_ras_n, sd_cas_n, sd_we_n} <= pat_d;
        sd_ba                         <= bank_d;
        sd_addr                       <= addr_d;
        if (is_cke) sd_cke <= 1'b1;
      end else if (reissue) begin
        sd_cs_n                       <= 1'b0;
        {sd_ras_n, sd_cas_n, sd_we_n} <= pat_of(K_REF);
      end
      if (reject) err <= 1'b1;
    end
  end

  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> busy); // R3
  AST_CKE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke); // R4
  AST_PALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]); // R5
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !kind_ok) |=> (!busy && sd_cs_n)); // R9
endmodule

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;
  localparam int T_RC = 7;

  typedef struct packed {
    logic [20:0] w;
    logic [2:0]  pat;
    logic [11:0] addr;
    logic [7:0]  blen;
    logic [4:0]  ncmd;
    logic [7:0]  gap;
  } vec_t;

  function automatic logic [20:0] mk(input int kind, input int bank, input int rep,
                                     input int mode);
    return {mode[11:0], rep[3:0], bank[1:0], kind[2:0]};
  endfunction

  localparam vec_t VECS [8] = '{
    '{mk(1, 0, 0, 0),      3'b111, 12'h000, 8'd1,   5'd1,  8'd0},  // R4 clock enable
    '{mk(2, 2, 0, 0),      3'b010, 12'h400, 8'd2,   5'd1,  8'd0},  // R5 precharge all
    '{mk(3, 1, 0, 0),      3'b001, 12'h000, 8'd7,   5'd1,  8'd7},  // R6 single refresh
    '{mk(3, 0, 7, 0),      3'b001, 12'h000, 8'd56,  5'd8,  8'd7},  // R6 eight refreshes
    '{mk(4, 0, 0, 12'h220), 3'b000, 12'h220, 8'd2,  5'd1,  8'd0},  // R7 BL1 CL2 single write
    '{mk(4, 3, 0, 12'h032), 3'b000, 12'h032, 8'd2,  5'd1,  8'd0},  // R7 BL4 CL3, bank 3
    '{mk(5, 1, 3, 0),      3'b111, 12'h000, 8'd0,   5'd0,  8'd0},  // R9 unsupported code
    '{mk(3, 2, 15, 0),     3'b001, 12'h000, 8'd112, 5'd16, 8'd7}   // R6 max count
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [20:0] cmd_word = '0;
  logic        busy, err, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdcmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .busy(busy), .err(err), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check_idle_state(input string tag);
    check(busy == 1'b0, tag, "busy", busy, 0);
    check(err == 1'b0, tag, "err", err, 0);
    check(sd_cke == 1'b0, tag, "cke", sd_cke, 0);
    check(sd_cs_n == 1'b1, tag, "cs_n", sd_cs_n, 1);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, tag, "ras/cas/we",
          {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state("R1 after reset");
  endtask

  task automatic run_vec(input vec_t v);
    int n = 0;
    int len = 0;
    cmd_word = v.w;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (busy && len < 500) begin
      if (!sd_cs_n) begin
        check({sd_ras_n, sd_cas_n, sd_we_n} == v.pat, "R3", "pin pattern",
              {sd_ras_n, sd_cas_n, sd_we_n}, v.pat);
        check(sd_addr == v.addr, "R3", "address", sd_addr, v.addr);
        check(sd_ba == v.w[4:3], "R2", "bank", sd_ba, v.w[4:3]);
        check(len == n * v.gap, "R6", "command position", len, n * v.gap);
        n++;
      end
      len++;
      @(negedge clk);
    end
    check(sd_cs_n == 1'b1, "R3", "deselect after busy", sd_cs_n, 1);
    check(len == v.blen, "R5/R6/R7", "busy length", len, v.blen);
    check(n == v.ncmd, "R6", "command count", n, v.ncmd);
    check(err == 1'b0, "R9", "err after accepted/unsupported", err, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      summary();
      $finish;
    end
  end

  initial begin : main
    int n;
    int len;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 8; i++) begin
      run_vec(VECS[i]);
      @(negedge clk);
    end
    check(sd_cke == 1'b1, "R4", "cke held after all commands", sd_cke, 1);

    // R8: write in the middle of a two-refresh run
    n = 0;
    len = 0;
    cmd_word = mk(3, 1, 1, 0);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    while (busy && len < 500) begin
      if (!sd_cs_n) begin
        check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001, "R8", "only refresh seen",
              {sd_ras_n, sd_cas_n, sd_we_n}, 3'b001);
        check(len == n * T_RC, "R8", "refresh spacing", len, n * T_RC);
        n++;
      end
      if (len == 3) begin
        cmd_word = mk(2, 0, 0, 0);
        cmd_wr = 1'b1;
      end else begin
        cmd_wr = 1'b0;
      end
      len++;
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check(n == 2, "R8", "refresh count", n, 2);
    check(len == 2 * T_RC, "R8", "busy length", len, 2 * T_RC);
    check(err == 1'b1, "R8", "err set", err, 1);
    repeat (4) @(negedge clk);
    check(err == 1'b1, "R8", "err sticky", err, 1);

    // R10: write on the last busy clock, then one clock later
    do_reset();
    check(sd_cke == 1'b0, "R4", "cke cleared by reset", sd_cke, 0);
    cmd_word = mk(2, 1, 0, 0);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(busy == 1'b1 && sd_cs_n == 1'b0, "R10", "precharge issued", busy, 1);
    @(negedge clk);
    check(busy == 1'b1, "R10", "last busy clock", busy, 1);
    cmd_word = mk(4, 0, 0, 12'h230);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(busy == 1'b0, "R10", "late write not accepted", busy, 0);
    check(sd_cs_n == 1'b1, "R10", "no command from late write", sd_cs_n, 1);
    check(err == 1'b1, "R10", "late write flagged", err, 1);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(sd_cs_n == 1'b0, "R10", "next-clock write issued", sd_cs_n, 0);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b000, "R7", "load mode pattern",
          {sd_ras_n, sd_cas_n, sd_we_n}, 3'b000);
    check(sd_addr == 12'h230, "R7", "mode payload", sd_addr, 12'h230);
    check(busy == 1'b1, "R10", "busy after accept", busy, 1);
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule